// File: doc/BRIEF.md
# Multicycle 32-bit Integer Core (Seven-Instruction Subset)

This block is a small 32-bit processor. It runs each instruction over several clock cycles and uses one memory port for both fetch and data. It supports seven instructions: register add, word load, word store, branch-if-equal, absolute jump, jump-and-link, and jump-through-register. Internally it holds a program counter, an instruction register, two operand latches (A, B), a result latch (Sum), a memory-data latch and a 32-entry register file. Register 0 always reads as zero.

A single control state machine walks every instruction through the same first two states, then takes a route that depends on the instruction class. The states are FETCH, DECODE, EXEC_ADD, WB_ADD, ADDR, MEM_RD, WB_LD, MEM_WR, BRANCH, JUMP and JREG.
- FETCH always goes to DECODE.
- DECODE goes to EXEC_ADD (add), ADDR (load or store), BRANCH (beq), JUMP (j and jal) or JREG (jr). Anything it does not recognise goes back to FETCH.
- EXEC_ADD goes to WB_ADD.
- ADDR goes to MEM_RD (load) or MEM_WR (store).
- MEM_RD goes to WB_LD.
- WB_ADD, WB_LD, MEM_WR, BRANCH, JUMP and JREG all go back to FETCH.

In DECODE the branch target is always computed into Sum, before the opcode is known. A beq then only has to compare the operands.

The memory port uses combinational reads. The address is the PC in FETCH and Sum in MEM_RD and MEM_WR. The write data is always B.

Top module: `mc_core`

## Requirements
- R1: While reset is held, and in the first cycle after it, the core is in FETCH with PC = 0. mem_addr_o is 0 and mem_we_o is 0.
- R2: FETCH loads IR from memory at PC and adds 4 to PC. DECODE always follows FETCH. IR holds its value outside FETCH. Cycles per instruction:
  - add: 4
  - lw: 5
  - sw: 4
  - beq, j, jal and jr: 3 each
  - any unrecognised word: 2
- R3: add is encoded as IR[31:26]=0 and IR[5:0]=32, with register fields rs=IR[25:21], rt=IR[20:16] and rd=IR[15:11]. It writes rs+rt, modulo 2^32, to rd.
- R4: lw is encoded as opcode 35 with a signed 16-bit immediate in IR[15:0]. It loads the word at rs+sext(imm) into rt.
- R5: sw is encoded as opcode 43. It writes rt to the address rs+sext(imm).
- R6: beq is encoded as opcode 4. When rs equals rt, PC becomes (address of the beq + 4) + (sext(imm) << 2), for forward and backward offsets alike. Otherwise execution falls through.
- R7: j is encoded as opcode 2. The new PC is {PC+4 [31:28], IR[25:0], 2'b00}.
- R8: jal is encoded as opcode 3. It jumps like j, and in the same cycle it writes (address of the jal + 4) to register 31.
- R9: jr is encoded as opcode 0 with funct 8. The new PC is the value of rs.
- R10: Register 0 reads as zero. Writes to it, by load or by add, are ignored.
- R11: Any other opcode, or opcode 0 with any other funct, returns to FETCH with no change to registers or memory.
- R12: mem_we_o is high for exactly one cycle per store, and never for any other instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr_o | output | 32 | Byte address for fetch or data access |
| mem_wdata_o | output | 32 | Store data (B latch) |
| mem_we_o | output | 1 | Memory write strobe |
| mem_rdata_i | input | 32 | Combinational read data at mem_addr_o |

## Verification
Two things happen in the same cycle in this block:
- In JUMP, a jal writes the link register and reloads the PC.
- In DECODE, every instruction reads A and B and, at the same time, computes the branch target into Sum.

The bench exercises both. In one program, a jal jumps over stores to a target that stores register 31. Landing at the target and seeing the right link value show that both halves of that cycle took effect. Branch-taken, not-taken and backward-branch programs, together with jr and the unrecognised-word programs, show that the early Sum only changes the PC when the compare succeeds. The bench judges every program by the memory image after it halts and by the cycle in which the first store appears on the port.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int XLEN = 32;

    localparam logic [5:0] OP_SPECIAL = 6'd0;
    localparam logic [5:0] OP_J       = 6'd2;
    localparam logic [5:0] OP_JAL     = 6'd3;
    localparam logic [5:0] OP_BEQ     = 6'd4;
    localparam logic [5:0] OP_LW      = 6'd35;
    localparam logic [5:0] OP_SW      = 6'd43;
    localparam logic [5:0] FN_JR      = 6'd8;
    localparam logic [5:0] FN_ADD     = 6'd32;

    typedef enum logic [3:0] {
        S_FETCH,
        S_DECODE,
        S_EXEC_ADD,
        S_WB_ADD,
        S_ADDR,
        S_MEM_RD,
        S_WB_LD,
        S_MEM_WR,
        S_BRANCH,
        S_JUMP,
        S_JREG
    } mc_state_e;

    typedef enum logic [1:0] {
        SUM_HOLD,
        SUM_BRANCH,
        SUM_ADD,
        SUM_ADDR
    } sum_sel_e;

    typedef enum logic [2:0] {
        PC_HOLD,
        PC_INC,
        PC_BEQ,
        PC_JUMP,
        PC_REG
    } pc_sel_e;

    typedef enum logic [1:0] {
        DST_RD,
        DST_RT,
        DST_LINK
    } rf_dst_e;

    typedef enum logic [1:0] {
        SRC_SUM,
        SRC_MDR,
        SRC_PC
    } rf_src_e;

    typedef struct packed {
        logic     ir_ld;
        logic     ab_ld;
        logic     mdr_ld;
        logic     addr_sum;
        logic     mem_we;
        logic     rf_we;
        sum_sel_e sum_sel;
        pc_sel_e  pc_sel;
        rf_dst_e  rf_dst;
        rf_src_e  rf_src;
    } mc_ctrl_t;

endpackage

// File: rtl/mc_regfile.sv
module mc_regfile
    import mc_pkg::*;
#(
    parameter int REG_CNT = 32,
    localparam int RA_W   = $clog2(REG_CNT)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RA_W-1:0] ra_i,
    input  logic [RA_W-1:0] rb_i,
    output logic [XLEN-1:0] da_o,
    output logic [XLEN-1:0] db_o,
    input  logic            we_i,
    input  logic [RA_W-1:0] wa_i,
    input  logic [XLEN-1:0] wd_i
);

    logic [XLEN-1:0] regs [REG_CNT];

    // Entry 0 is hard-wired to zero; writes to it are dropped
    assign regs[0] = '0;

    for (genvar g = 1; g < REG_CNT; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (we_i && (wa_i == RA_W'(g))) begin
                regs[g] <= wd_i;
            end
        end
    end

    assign da_o = regs[ra_i];
    assign db_o = regs[rb_i];

endmodule

// File: rtl/mc_fsm.sv
module mc_fsm
    import mc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic [5:0] opcode_i,
    input  logic [5:0] funct_i,
    output mc_state_e state_o,
    output mc_ctrl_t  ctrl_o
);

    mc_state_e state_q;
    mc_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = S_FETCH;
        unique case (state_q)
            S_FETCH:    state_d = S_DECODE;
            S_DECODE: begin
                if (opcode_i == OP_SPECIAL && funct_i == FN_ADD) begin
                    state_d = S_EXEC_ADD;
                end else if (opcode_i == OP_SPECIAL && funct_i == FN_JR) begin
                    state_d = S_JREG;
                end else if (opcode_i == OP_LW || opcode_i == OP_SW) begin
                    state_d = S_ADDR;
                end else if (opcode_i == OP_BEQ) begin
                    state_d = S_BRANCH;
                end else if (opcode_i == OP_J || opcode_i == OP_JAL) begin
                    state_d = S_JUMP;
                end else begin
                    state_d = S_FETCH;
                end
            end
            S_EXEC_ADD: state_d = S_WB_ADD;
            S_ADDR:     state_d = (opcode_i == OP_LW) ? S_MEM_RD : S_MEM_WR;
            S_MEM_RD:   state_d = S_WB_LD;
            S_WB_ADD,
            S_WB_LD,
            S_MEM_WR,
            S_BRANCH,
            S_JUMP,
            S_JREG:     state_d = S_FETCH;
            default:    state_d = S_FETCH;
        endcase
    end

    // Outputs
    always_comb begin
        ctrl_o = '{
            ir_ld:    1'b0,
            ab_ld:    1'b0,
            mdr_ld:   1'b0,
            addr_sum: 1'b0,
            mem_we:   1'b0,
            rf_we:    1'b0,
            sum_sel:  SUM_HOLD,
            pc_sel:   PC_HOLD,
            rf_dst:   DST_RD,
            rf_src:   SRC_SUM
        };
        unique case (state_q)
            S_FETCH: begin
                ctrl_o.ir_ld  = 1'b1;
                ctrl_o.pc_sel = PC_INC;
            end
            S_DECODE: begin
                ctrl_o.ab_ld   = 1'b1;
                ctrl_o.sum_sel = SUM_BRANCH;
            end
            S_EXEC_ADD: ctrl_o.sum_sel = SUM_ADD;
            S_WB_ADD: begin
                ctrl_o.rf_we  = 1'b1;
                ctrl_o.rf_dst = DST_RD;
                ctrl_o.rf_src = SRC_SUM;
            end
            S_ADDR:     ctrl_o.sum_sel = SUM_ADDR;
            S_MEM_RD: begin
                ctrl_o.addr_sum = 1'b1;
                ctrl_o.mdr_ld   = 1'b1;
            end
            S_WB_LD: begin
                ctrl_o.rf_we  = 1'b1;
                ctrl_o.rf_dst = DST_RT;
                ctrl_o.rf_src = SRC_MDR;
            end
            S_MEM_WR: begin
                ctrl_o.addr_sum = 1'b1;
                ctrl_o.mem_we   = 1'b1;
            end
            S_BRANCH:   ctrl_o.pc_sel = PC_BEQ;
            S_JUMP: begin
                ctrl_o.pc_sel = PC_JUMP;
                ctrl_o.rf_we  = (opcode_i == OP_JAL);
                ctrl_o.rf_dst = DST_LINK;
                ctrl_o.rf_src = SRC_PC;
            end
            S_JREG:     ctrl_o.pc_sel = PC_REG;
            default: ;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
    import mc_pkg::*;
#(
    parameter int REG_CNT = 32,
    localparam int RA_W   = $clog2(REG_CNT)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  mc_ctrl_t        ctrl_i,
    input  logic [XLEN-1:0] mem_rdata_i,
    output logic [XLEN-1:0] mem_addr_o,
    output logic [XLEN-1:0] mem_wdata_o,
    output logic [XLEN-1:0] pc_o,
    output logic [XLEN-1:0] ir_o,
    output logic [XLEN-1:0] a_o,
    output logic [XLEN-1:0] b_o,
    output logic [XLEN-1:0] sum_o,
    output logic            rf_we_o,
    output logic [RA_W-1:0] rf_waddr_o
);

    logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, sum_q, mdr_q;
    logic [XLEN-1:0] rf_da, rf_db, rf_wd;
    logic [XLEN-1:0] imm_se, br_off, jmp_tgt;
    logic [RA_W-1:0] rs_idx, rt_idx, rd_idx;

    assign rs_idx  = ir_q[21 +: RA_W];
    assign rt_idx  = ir_q[16 +: RA_W];
    assign rd_idx  = ir_q[11 +: RA_W];
    assign imm_se  = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};
    assign br_off  = {imm_se[XLEN-3:0], 2'b00};
    assign jmp_tgt = {pc_q[XLEN-1 -: 4], ir_q[25:0], 2'b00};

    // Register file write steering
    always_comb begin
        rf_waddr_o = rd_idx;
        unique case (ctrl_i.rf_dst)
            DST_RD:   rf_waddr_o = rd_idx;
            DST_RT:   rf_waddr_o = rt_idx;
            DST_LINK: rf_waddr_o = RA_W'(REG_CNT - 1);
            default:  rf_waddr_o = rd_idx;
        endcase
        rf_wd = sum_q;
        unique case (ctrl_i.rf_src)
            SRC_SUM: rf_wd = sum_q;
            SRC_MDR: rf_wd = mdr_q;
            SRC_PC:  rf_wd = pc_q;
            default: rf_wd = sum_q;
        endcase
    end

    assign rf_we_o = ctrl_i.rf_we;

    mc_regfile #(.REG_CNT(REG_CNT)) rf_i (
        .clk   (clk),
        .rst_n (rst_n),
        .ra_i  (rs_idx),
        .rb_i  (rt_idx),
        .da_o  (rf_da),
        .db_o  (rf_db),
        .we_i  (ctrl_i.rf_we),
        .wa_i  (rf_waddr_o),
        .wd_i  (rf_wd)
    );

    // Program counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            unique case (ctrl_i.pc_sel)
                PC_HOLD: pc_q <= pc_q;
                PC_INC:  pc_q <= pc_q + XLEN'(4);
                PC_BEQ:  pc_q <= (a_q == b_q) ? sum_q : pc_q;
                PC_JUMP: pc_q <= jmp_tgt;
                PC_REG:  pc_q <= a_q;
                default: pc_q <= pc_q;
            endcase
        end
    end

    // Instruction, operand and memory-data latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir_q  <= '0;
            a_q   <= '0;
            b_q   <= '0;
            mdr_q <= '0;
        end else begin
            if (ctrl_i.ir_ld)  ir_q  <= mem_rdata_i;
            if (ctrl_i.ab_ld) begin
                a_q <= rf_da;
                b_q <= rf_db;
            end
            if (ctrl_i.mdr_ld) mdr_q <= mem_rdata_i;
        end
    end

    // Result latch: branch target speculated in decode, then ALU result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else begin
            unique case (ctrl_i.sum_sel)
                SUM_HOLD:   sum_q <= sum_q;
                SUM_BRANCH: sum_q <= pc_q + br_off;
                SUM_ADD:    sum_q <= a_q + b_q;
                SUM_ADDR:   sum_q <= a_q + imm_se;
                default:    sum_q <= sum_q;
            endcase
        end
    end

    assign mem_addr_o  = ctrl_i.addr_sum ? sum_q : pc_q;
    assign mem_wdata_o = b_q;
    assign pc_o        = pc_q;
    assign ir_o        = ir_q;
    assign a_o         = a_q;
    assign b_o         = b_q;
    assign sum_o       = sum_q;

endmodule

// File: rtl/mc_core.sv
module mc_core
    import mc_pkg::*;
#(
    parameter int REG_CNT = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [31:0] mem_addr_o,
    output logic [31:0] mem_wdata_o,
    output logic        mem_we_o,
    input  logic [31:0] mem_rdata_i
);

    localparam int RA_W = $clog2(REG_CNT);

    mc_state_e       state_q;
    mc_ctrl_t        ctrl;
    logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, sum_q;
    logic            rf_we;
    logic [RA_W-1:0] rf_waddr;

    mc_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .opcode_i (ir_q[31:26]),
        .funct_i  (ir_q[5:0]),
        .state_o  (state_q),
        .ctrl_o   (ctrl)
    );

    mc_datapath #(.REG_CNT(REG_CNT)) dp_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_i      (ctrl),
        .mem_rdata_i (mem_rdata_i),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .pc_o        (pc_q),
        .ir_o        (ir_q),
        .a_o         (a_q),
        .b_o         (b_q),
        .sum_o       (sum_q),
        .rf_we_o     (rf_we),
        .rf_waddr_o  (rf_waddr)
    );

    assign mem_we_o = ctrl.mem_we;

endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
    import mc_pkg::*;
#(
    parameter int RA_W = 5
) (
    input logic            clk,
    input logic            rst_n,
    input mc_state_e       state,
    input logic [XLEN-1:0] pc,
    input logic [XLEN-1:0] ir,
    input logic [XLEN-1:0] a,
    input logic [XLEN-1:0] b,
    input logic [XLEN-1:0] sum,
    input logic            mem_we,
    input logic            rf_we,
    input logic [RA_W-1:0] rf_waddr
);

    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    AST_RESET_START: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> (state == S_FETCH && pc == '0)); // R1

    AST_DECODE_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_FETCH |=> state == S_DECODE); // R2

    AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_FETCH |=> pc == $past(pc) + XLEN'(4)); // R2

    AST_IR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        state != S_FETCH |=> $stable(ir)); // R2

    AST_BEQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BRANCH && a == b) |=> pc == $past(sum)); // R6

    AST_BEQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BRANCH && a != b) |=> $stable(pc)); // R6

    AST_LINK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_JUMP && ir[31:26] == OP_JAL) |-> (rf_we && rf_waddr == '1)); // R8

    AST_JR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_JREG |=> pc == $past(a)); // R9

    AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DECODE && ir[25:21] == 5'd0) |=> a == '0); // R10

    AST_STORE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we); // R12

    AST_STORE_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> state == S_FETCH); // R5

    AST_STORE_B_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_MEM_WR |-> $stable(b)); // R5

endmodule

bind mc_core mc_core_chk #(.RA_W(RA_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state_q),
    .pc       (pc_q),
    .ir       (ir_q),
    .a        (a_q),
    .b        (b_q),
    .sum      (sum_q),
    .mem_we   (mem_we_o),
    .rf_we    (rf_we),
    .rf_waddr (rf_waddr)
);

// File: tb/mc_core_tb_top.sv
`timescale 1ns/1ps
module mc_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we;

    always #2 clk = ~clk;

    mc_core dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_we_o    (mem_we),
        .mem_rdata_i (mem_rdata)
    );

    logic [31:0] image [64];
    logic [31:0] mem   [64];
    int          cyc, wr_cnt, first_wr;
    logic [31:0] last_wr_addr;
    int          total = 0;
    int          bad   = 0;

    assign mem_rdata = mem[mem_addr[7:2]];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= image[i];
            cyc          <= 0;
            wr_cnt       <= 0;
            first_wr     <= 0;
            last_wr_addr <= '0;
        end else begin
            cyc <= cyc + 1;
            if (mem_we) begin
                mem[mem_addr[7:2]] <= mem_wdata;
                wr_cnt             <= wr_cnt + 1;
                last_wr_addr       <= mem_addr;
                if (first_wr == 0) first_wr <= cyc + 1;
            end
        end
    end

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
    endfunction
    function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_j(int op, int widx);
        return {6'(op), 26'(widx)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic clear_image();
        for (int i = 0; i < 32; i++) image[i] = 32'h0;
        for (int i = 32; i < 64; i++) image[i] = 32'hDEAD0000 | 32'(i);
    endtask

    task automatic run(input int cycles);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (cycles) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog got=%h exp=%h", 32'd0, 32'd1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] va, vb;

        // R1: reset state
        clear_image();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset addr", mem_addr, 32'h0);
        chk("R1 reset we", 32'(mem_we), 32'h0);
        rst_n = 1'b1;
        #1;
        chk("R1 first fetch addr", mem_addr, 32'h0);

        // R3 R4 R5 R2: add sweep across register numbers and values
        for (int k = 0; k < 16; k++) begin
            va = 32'h9E3779B9 * 32'(k + 1);
            vb = ~va + 32'(k);
            clear_image();
            image[32] = va;
            image[33] = vb;
            image[0] = enc_i(35, 0, k + 1, 'h80);
            image[1] = enc_i(35, 0, k + 9, 'h84);
            image[2] = enc_r(k + 1, k + 9, k + 16, 32);
            image[3] = enc_i(43, 0, k + 16, 'h90);
            image[4] = enc_j(2, 4);
            run(40);
            chk("R3 add sum", mem[36], va + vb);
            chk("R2 add/lw cycle count", 32'(first_wr), 32'd18);
            chk("R12 single store", 32'(wr_cnt), 32'd1);
        end

        // R4 R5: negative offsets
        clear_image();
        image[32] = 32'h000000A0;
        image[38] = 32'h13579BDF;
        image[0] = enc_i(35, 0, 4, 'h80);
        image[1] = enc_i(35, 4, 5, -8);
        image[2] = enc_i(43, 4, 5, -4);
        image[3] = enc_j(2, 3);
        run(40);
        chk("R4 lw negative offset", mem[39], 32'h13579BDF);
        chk("R5 sw address", last_wr_addr, 32'h9C);
        chk("R5 source untouched", mem[38], 32'h13579BDF);

        // R10: register 0
        clear_image();
        image[32] = 32'h0000_1234;
        image[33] = 32'hFFFF_0001;
        image[0] = enc_i(35, 0, 1, 'h80);
        image[1] = enc_i(35, 0, 0, 'h84);
        image[2] = enc_i(43, 0, 0, 'h90);
        image[3] = enc_r(1, 1, 0, 32);
        image[4] = enc_i(43, 0, 0, 'h94);
        image[5] = enc_r(0, 1, 6, 32);
        image[6] = enc_i(43, 0, 6, 'h98);
        image[7] = enc_j(2, 7);
        run(60);
        chk("R10 load to r0 ignored", mem[36], 32'h0);
        chk("R10 add to r0 ignored", mem[37], 32'h0);
        chk("R10 r0 reads zero", mem[38], 32'h1234);
        chk("R2 lw+lw+sw cycles", 32'(first_wr), 32'd14);

        // R6: beq taken and not taken
        for (int t = 0; t < 2; t++) begin
            clear_image();
            image[32] = 32'hCAFE0001;
            image[33] = (t == 0) ? 32'hCAFE0001 : 32'hCAFE0002;
            image[0] = enc_i(35, 0, 1, 'h80);
            image[1] = enc_i(35, 0, 2, 'h84);
            image[2] = enc_i(4, 1, 2, 1);
            image[3] = enc_i(43, 0, 1, 'h90);
            image[4] = enc_i(43, 0, 2, 'h94);
            image[5] = enc_j(2, 5);
            run(50);
            chk("R6 beq skip target", mem[36], (t == 0) ? (32'hDEAD0000 | 32'd36) : 32'hCAFE0001);
            chk("R6 beq next store", mem[37], image[33]);
            chk("R2 beq cycles", 32'(first_wr), 32'd17);
        end

        // R6 R7: jump forward, then backward branch
        clear_image();
        image[34] = 32'h0BADF00D;
        image[0] = enc_j(2, 4);
        image[1] = enc_i(35, 0, 3, 'h88);
        image[2] = enc_i(43, 0, 3, 'h90);
        image[3] = enc_j(2, 3);
        image[4] = enc_i(4, 0, 0, -4);
        run(40);
        chk("R6 backward branch", mem[36], 32'h0BADF00D);
        chk("R7 j then beq cycles", 32'(first_wr), 32'd15);
        chk("R7 no skipped store", 32'(wr_cnt), 32'd1);

        // R8: jal link and target in the same step
        clear_image();
        image[32] = 32'h55;
        image[0] = enc_i(35, 0, 1, 'h80);
        image[1] = enc_j(3, 4);
        image[2] = enc_i(43, 0, 1, 'h94);
        image[3] = enc_i(43, 0, 1, 'h98);
        image[4] = enc_i(43, 0, 31, 'h90);
        image[5] = enc_j(2, 5);
        run(40);
        chk("R8 link value", mem[36], 32'h8);
        chk("R8 jal cycles", 32'(first_wr), 32'd12);
        chk("R8 skipped stores", 32'(wr_cnt), 32'd1);

        // R9: jr
        clear_image();
        image[32] = 32'h14;
        image[0] = enc_i(35, 0, 7, 'h80);
        image[1] = enc_r(7, 0, 0, 8);
        image[2] = enc_i(43, 0, 7, 'h94);
        image[3] = enc_i(43, 0, 7, 'h94);
        image[4] = enc_i(43, 0, 7, 'h94);
        image[5] = enc_i(43, 0, 7, 'h90);
        image[6] = enc_j(2, 6);
        run(40);
        chk("R9 jr target", mem[36], 32'h14);
        chk("R9 jr cycles", 32'(first_wr), 32'd12);
        chk("R9 skipped stores", 32'(wr_cnt), 32'd1);

        // R11: unrecognised words change nothing
        clear_image();
        image[32] = 32'h7777_8888;
        image[0] = enc_i(35, 0, 1, 'h80);
        image[1] = enc_i(8, 0, 1, 5);
        image[2] = enc_r(1, 1, 1, 34);
        image[3] = enc_i(43, 0, 1, 'h90);
        image[4] = enc_j(2, 4);
        run(40);
        chk("R11 register unchanged", mem[36], 32'h7777_8888);
        chk("R11 two-cycle skip", 32'(first_wr), 32'd13);
        chk("R12 store count", 32'(wr_cnt), 32'd1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule